// File: doc/BRIEF.md
# Thread Lifecycle Manager

This block holds the lifecycle of every thread slot of a hardware-assisted real-time kernel. Software or another hardware unit issues one low-level command per cycle: allocate a slot, make it runnable, block one thread on the termination of another, terminate a thread, release a terminated slot, or designate the idle thread. For each slot the block records an allocation state, a detached/joinable attribute and an optional waiting-thread link. Each command gets a result one cycle after acceptance. When a thread becomes runnable, a one-cycle enqueue pulse carrying its identifier goes to the scheduler.

Allocation, readiness, termination and release are separate steps. A terminated slot keeps its record until it is released explicitly, so a late joiner can still see that it finished. The scheduler treats a thread in the READY state as "ready or running". A JOIN is issued on behalf of such a running caller. The idle thread must be a created thread that has never been made ready. It is never enqueued and cannot be released.

Top module: `thm_lifecycle`

## Requirements
- R1: After reset all slots are free, no idle thread is set (`idle_valid`=0) and `rsp_valid` and `enq_valid` are low.
- R2: CREATE (op 0) allocates the lowest-numbered free slot and returns status OK (0) with that slot number in `rsp_tid`. `cmd_arg[0]`=1 marks the thread detached. The new thread is not enqueued. With no free slot the status is FULL (2) and `rsp_tid` is 0.
- R3: ADD (op 1) on a created, never-readied, non-idle thread returns OK and pulses `enq_valid` with `enq_tid`=`cmd_tid` in the response cycle. ADD on a free, ready, blocked, terminated or idle thread returns ILLEGAL (3) and no enqueue.
- R4: JOIN (op 2, target `cmd_tid`, caller `cmd_arg`) blocks a ready caller on a live joinable target and returns BLOCKED (1). It returns ILLEGAL if the caller is the target, the caller is not ready, the target is free or detached, or the target already has a waiter.
- R5: JOIN on a terminated joinable target returns OK at once and leaves the caller ready.
- R6: EXIT (op 3) on a ready thread marks it terminated and returns OK. If it had a waiter, that waiter becomes ready and is enqueued in the response cycle. EXIT on any other state returns ILLEGAL.
- R7: CLEAR (op 4) on a terminated thread frees its slot with OK, and a later CREATE can reuse it. CLEAR in any other state returns ILLEGAL.
- R8: IDLE (op 5) on a created, never-readied thread sets `idle_tid` and `idle_valid`. On any other state it returns ILLEGAL. The idle outputs change only on a successful IDLE.
- R9: A command is accepted in every cycle where `cmd_valid` is high. Its response appears in exactly the following cycle, so each command finishes in one cycle.
- R10: Opcodes 6 and 7 return BADOP (4) with no effect.
- R11: A command answered with ILLEGAL, FULL or BADOP changes no slot. Later commands on the same slots behave as if it had not been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation code |
| cmd_tid | input | TW | Subject/target thread |
| cmd_arg | input | TW | Caller for JOIN; bit 0 = detached for CREATE |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 3 | Result code |
| rsp_tid | output | TW | Allocated slot (CREATE) or subject thread |
| enq_valid | output | 1 | Enqueue request to scheduler |
| enq_tid | output | TW | Thread to enqueue |
| idle_valid | output | 1 | An idle thread is designated |
| idle_tid | output | TW | Designated idle thread |

## Verification
The hardest state to reach is a completely full table. Only then can the FULL result and lowest-free reuse be seen. The stimulus allocates every slot in sequence and then frees one slot in the middle of the range. A second hard case is the waiter wake-up, which needs a target that is ready, joined and then exited. The bench builds this chain on purpose and runs it together with the self-join, detached-join and double-join refusals. The terminated target is then joined again to show that the join returns immediately.

// File: rtl/thm_pkg.sv
// Shared encodings for the thread lifecycle manager.
package thm_pkg;
    localparam logic [2:0] OP_CREATE = 3'd0;
    localparam logic [2:0] OP_ADD    = 3'd1;
    localparam logic [2:0] OP_JOIN   = 3'd2;
    localparam logic [2:0] OP_EXIT   = 3'd3;
    localparam logic [2:0] OP_CLEAR  = 3'd4;
    localparam logic [2:0] OP_IDLE   = 3'd5;

    localparam logic [2:0] RS_OK      = 3'd0;
    localparam logic [2:0] RS_BLOCKED = 3'd1;
    localparam logic [2:0] RS_FULL    = 3'd2;
    localparam logic [2:0] RS_ILLEGAL = 3'd3;
    localparam logic [2:0] RS_BADOP   = 3'd4;

    typedef enum logic [2:0] {
        TS_FREE    = 3'd0,
        TS_CREATED = 3'd1,
        TS_READY   = 3'd2,
        TS_BLOCKED = 3'd3,
        TS_DONE    = 3'd4
    } tstate_e;
endpackage

// File: rtl/thm_free_finder.sv
// Lowest-index-first search over a vector of free flags.
// Assumes N fits in TW bits of index; purely combinational.
module thm_free_finder #(
    parameter int N  = 256,
    parameter int TW = $clog2(N)
) (
    input  logic [N-1:0]  free_vec,
    output logic          found,
    output logic [TW-1:0] idx
);
    // Scan from the top so the lowest set flag is the last one written.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                found = 1'b1;
                idx   = TW'(i);
            end
        end
    end
endmodule

// File: rtl/thm_table.sv
// Per-slot thread records: state, detached flag, waiter link.
// Two combinational read ports, two write ports. Port A writes a full
// record, port B writes the state only. The controller never aims both
// ports at the same slot in one cycle. If it did, port A would win.
module thm_table
    import thm_pkg::*;
#(
    parameter int N  = 256,
    parameter int TW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] ra_addr,
    output tstate_e       ra_state,
    output logic          ra_det,
    output logic          ra_wv,
    output logic [TW-1:0] ra_wid,
    input  logic [TW-1:0] rb_addr,
    output tstate_e       rb_state,
    input  logic          wa_en,
    input  logic [TW-1:0] wa_addr,
    input  tstate_e       wa_state,
    input  logic          wa_det,
    input  logic          wa_wv,
    input  logic [TW-1:0] wa_wid,
    input  logic          wb_en,
    input  logic [TW-1:0] wb_addr,
    input  tstate_e       wb_state,
    output logic [N-1:0]  free_vec
);
    tstate_e       st_q  [N];
    logic [N-1:0]  det_q;
    logic [N-1:0]  wv_q;
    logic [TW-1:0] wid_q [N];

    // Read ports.
    always_comb begin
        ra_state = st_q[ra_addr];
        ra_det   = det_q[ra_addr];
        ra_wv    = wv_q[ra_addr];
        ra_wid   = wid_q[ra_addr];
        rb_state = st_q[rb_addr];
    end

    // Free flags, one per slot.
    for (genvar g = 0; g < N; g++) begin : g_free
        assign free_vec[g] = (st_q[g] == TS_FREE);
    end

    // Record storage with reset to all-free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                st_q[i]  <= TS_FREE;
                wid_q[i] <= '0;
            end
            det_q <= '0;
            wv_q  <= '0;
        end else begin
            if (wb_en) st_q[wb_addr] <= wb_state;
            if (wa_en) begin
                st_q[wa_addr]  <= wa_state;
                det_q[wa_addr] <= wa_det;
                wv_q[wa_addr]  <= wa_wv;
                wid_q[wa_addr] <= wa_wid;
            end
        end
    end
endmodule

// File: rtl/thm_lifecycle.sv
// Thread lifecycle manager top. It decodes one command per cycle against
// the slot table, updates at most two slots, and registers the response,
// the scheduler enqueue pulse and the idle-thread designation.
// Assumes NUM_THREADS is a power of two.
module thm_lifecycle
    import thm_pkg::*;
#(
    parameter int NUM_THREADS = 256,
    parameter int TW          = $clog2(NUM_THREADS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [TW-1:0] cmd_tid,
    input  logic [TW-1:0] cmd_arg,
    output logic          rsp_valid,
    output logic [2:0]    rsp_status,
    output logic [TW-1:0] rsp_tid,
    output logic          enq_valid,
    output logic [TW-1:0] enq_tid,
    output logic          idle_valid,
    output logic [TW-1:0] idle_tid
);
    tstate_e       a_state, b_state, wa_state, wb_state;
    logic          a_det, a_wv, wa_en, wa_det, wa_wv, wb_en;
    logic [TW-1:0] a_wid, wa_addr, wa_wid, wb_addr;
    logic [NUM_THREADS-1:0] free_vec;
    logic          free_found;
    logic [TW-1:0] free_idx;
    logic [2:0]    st_d;
    logic [TW-1:0] tid_d, enq_tid_d;
    logic          enq_d, idle_set, is_idle;

    thm_table #(.N(NUM_THREADS), .TW(TW)) u_table (
        .clk(clk), .rst_n(rst_n),
        .ra_addr(cmd_tid), .ra_state(a_state), .ra_det(a_det),
        .ra_wv(a_wv), .ra_wid(a_wid),
        .rb_addr(cmd_arg), .rb_state(b_state),
        .wa_en(wa_en), .wa_addr(wa_addr), .wa_state(wa_state),
        .wa_det(wa_det), .wa_wv(wa_wv), .wa_wid(wa_wid),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_state(wb_state),
        .free_vec(free_vec)
    );

    thm_free_finder #(.N(NUM_THREADS), .TW(TW)) u_find (
        .free_vec(free_vec), .found(free_found), .idx(free_idx)
    );

    assign is_idle = idle_valid && (idle_tid == cmd_tid);

    // Command decode: result code, slot writes and enqueue request.
    always_comb begin
        wa_en     = 1'b0;
        wa_addr   = cmd_tid;
        wa_state  = a_state;
        wa_det    = a_det;
        wa_wv     = a_wv;
        wa_wid    = a_wid;
        wb_en     = 1'b0;
        wb_addr   = cmd_arg;
        wb_state  = b_state;
        st_d      = RS_ILLEGAL;
        tid_d     = cmd_tid;
        enq_d     = 1'b0;
        enq_tid_d = cmd_tid;
        idle_set  = 1'b0;
        unique case (cmd_op)
            OP_CREATE: begin
                if (free_found) begin
                    wa_en    = 1'b1;
                    wa_addr  = free_idx;
                    wa_state = TS_CREATED;
                    wa_det   = cmd_arg[0];
                    wa_wv    = 1'b0;
                    wa_wid   = '0;
                    st_d     = RS_OK;
                    tid_d    = free_idx;
                end else begin
                    st_d  = RS_FULL;
                    tid_d = '0;
                end
            end
            OP_ADD: begin
                if (a_state == TS_CREATED && !is_idle) begin
                    wa_en    = 1'b1;
                    wa_state = TS_READY;
                    st_d     = RS_OK;
                    enq_d    = 1'b1;
                end
            end
            OP_JOIN: begin
                if (cmd_arg == cmd_tid || b_state != TS_READY ||
                    a_state == TS_FREE || a_det) begin
                    st_d = RS_ILLEGAL;
                end else if (a_state == TS_DONE) begin
                    st_d = RS_OK;
                end else if (!a_wv) begin
                    wa_en    = 1'b1;
                    wa_wv    = 1'b1;
                    wa_wid   = cmd_arg;
                    wb_en    = 1'b1;
                    wb_state = TS_BLOCKED;
                    st_d     = RS_BLOCKED;
                end
            end
            OP_EXIT: begin
                if (a_state == TS_READY) begin
                    wa_en    = 1'b1;
                    wa_state = TS_DONE;
                    wa_wv    = 1'b0;
                    st_d     = RS_OK;
                    if (a_wv) begin
                        wb_en     = 1'b1;
                        wb_addr   = a_wid;
                        wb_state  = TS_READY;
                        enq_d     = 1'b1;
                        enq_tid_d = a_wid;
                    end
                end
            end
            OP_CLEAR: begin
                if (a_state == TS_DONE && !is_idle) begin
                    wa_en    = 1'b1;
                    wa_state = TS_FREE;
                    wa_det   = 1'b0;
                    wa_wv    = 1'b0;
                    wa_wid   = '0;
                    st_d     = RS_OK;
                end
            end
            OP_IDLE: begin
                if (a_state == TS_CREATED) begin
                    idle_set = 1'b1;
                    st_d     = RS_OK;
                end
            end
            default: st_d = RS_BADOP;
        endcase
        wa_en    = wa_en & cmd_valid;
        wb_en    = wb_en & cmd_valid;
        enq_d    = enq_d & cmd_valid;
        idle_set = idle_set & cmd_valid;
    end

    // Registered response, enqueue pulse and idle designation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_status <= RS_OK;
            rsp_tid    <= '0;
            enq_valid  <= 1'b0;
            enq_tid    <= '0;
            idle_valid <= 1'b0;
            idle_tid   <= '0;
        end else begin
            rsp_valid  <= cmd_valid;
            rsp_status <= st_d;
            rsp_tid    <= tid_d;
            enq_valid  <= enq_d;
            enq_tid    <= enq_tid_d;
            if (idle_set) begin
                idle_valid <= 1'b1;
                idle_tid   <= cmd_tid;
            end
        end
    end
endmodule

// File: rtl/thm_checker.sv
// Protocol properties of the lifecycle manager, attached by bind.
module thm_checker #(
    parameter int TW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [2:0]    cmd_op,
    input logic          rsp_valid,
    input logic [2:0]    rsp_status,
    input logic          enq_valid,
    input logic          idle_valid,
    input logic [TW-1:0] idle_tid
);
    p_rsp_next_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);
    p_no_spurious_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);
    p_enq_only_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
        enq_valid |-> (rsp_valid && rsp_status == 3'd0));
    p_enq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op != 3'd1 && cmd_op != 3'd3) |=> !enq_valid);
    p_badop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op > 3'd5) |=> (rsp_status == 3'd4 && !enq_valid));
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_op == 3'd5) |=> ($stable(idle_valid) && $stable(idle_tid)));
endmodule

bind thm_lifecycle thm_checker #(.TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .enq_valid(enq_valid),
    .idle_valid(idle_valid), .idle_tid(idle_tid)
);

// File: tb/sim_thm_lifecycle.sv
`timescale 1ns/1ps
module sim_thm_lifecycle;
    localparam int N  = 256;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [TW-1:0] cmd_tid = '0;
    logic [TW-1:0] cmd_arg = '0;
    logic          rsp_valid, enq_valid, idle_valid;
    logic [2:0]    rsp_status;
    logic [TW-1:0] rsp_tid, enq_tid, idle_tid;

    int checks = 0;
    int errors = 0;

    // Reference model: 0 free, 1 created, 2 ready, 3 blocked, 4 done.
    int m_st  [N];
    int m_det [N];
    int m_wait[N];   // -1 = no waiter
    int m_idle = -1;

    always #4 clk = ~clk;

    thm_lifecycle #(.NUM_THREADS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_tid(cmd_tid), .cmd_arg(cmd_arg), .rsp_valid(rsp_valid),
        .rsp_status(rsp_status), .rsp_tid(rsp_tid), .enq_valid(enq_valid),
        .enq_tid(enq_tid), .idle_valid(idle_valid), .idle_tid(idle_tid)
    );

    // Drive one command, predict, then compare one cycle later.
    task automatic run_cmd(input int op, input int t, input int a, input string req);
        int es, et, ee, eet;
        es = 3; et = t; ee = 0; eet = 0;
        case (op)
            0: begin
                et = -1;
                for (int i = 0; i < N; i++) if (et < 0 && m_st[i] == 0) et = i;
                if (et < 0) begin es = 2; et = 0; end
                else begin es = 0; m_st[et] = 1; m_det[et] = a & 1; m_wait[et] = -1; end
            end
            1: if (m_st[t] == 1 && m_idle != t) begin
                   es = 0; m_st[t] = 2; ee = 1; eet = t;
               end
            2: begin
                if (a == t || m_st[a] != 2 || m_st[t] == 0 || m_det[t] == 1) es = 3;
                else if (m_st[t] == 4) es = 0;
                else if (m_wait[t] >= 0) es = 3;
                else begin es = 1; m_wait[t] = a; m_st[a] = 3; end
            end
            3: if (m_st[t] == 2) begin
                   es = 0; m_st[t] = 4;
                   if (m_wait[t] >= 0) begin
                       ee = 1; eet = m_wait[t]; m_st[m_wait[t]] = 2;
                   end
                   m_wait[t] = -1;
               end
            4: if (m_st[t] == 4 && m_idle != t) begin
                   es = 0; m_st[t] = 0; m_det[t] = 0; m_wait[t] = -1;
               end
            5: if (m_st[t] == 1) begin es = 0; m_idle = t; end
            default: es = 4;
        endcase
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_tid = TW'(t); cmd_arg = TW'(a);
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b1 || rsp_status !== 3'(es) || rsp_tid !== TW'(et) ||
            enq_valid !== 1'(ee) || (ee == 1 && enq_tid !== TW'(eet)) ||
            idle_valid !== (m_idle >= 0) || (m_idle >= 0 && idle_tid !== TW'(m_idle))) begin
            errors++;
            $display("FAIL %s op%0d tid%0d arg%0d: got v%0b st%0d tid%0d enq%0b/%0d idle%0b/%0d exp st%0d tid%0d enq%0d/%0d idle%0d",
                     req, op, t, a, rsp_valid, rsp_status, rsp_tid, enq_valid, enq_tid,
                     idle_valid, idle_tid, es, et, ee, eet, m_idle);
        end
    endtask

    // A cycle with no command: no response, no enqueue (R9).
    task automatic quiet_cycle();
        cmd_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || enq_valid !== 1'b0) begin
            errors++;
            $display("FAIL R9 quiet cycle: got rsp%0b enq%0b exp 0 0", rsp_valid, enq_valid);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, got hang exp completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_st[i] = 0; m_det[i] = 0; m_wait[i] = -1; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || enq_valid !== 1'b0 || idle_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: got rsp%0b enq%0b idle%0b exp 0 0 0",
                     rsp_valid, enq_valid, idle_valid);
        end
        run_cmd(0, 0, 0, "R2");  // -> 0 joinable
        run_cmd(0, 0, 1, "R2");  // -> 1 detached
        run_cmd(0, 0, 0, "R2");  // -> 2
        run_cmd(1, 0, 0, "R3");  // ready 0, enqueue
        run_cmd(1, 0, 0, "R3");  // already ready
        run_cmd(1, 5, 0, "R3");  // free slot
        run_cmd(5, 5, 0, "R8");  // idle on free slot
        run_cmd(5, 2, 0, "R8");  // idle = 2
        run_cmd(1, 2, 0, "R8");  // idle cannot be added
        quiet_cycle();
        run_cmd(0, 0, 0, "R2");  // -> 3
        run_cmd(1, 1, 0, "R3");
        run_cmd(1, 3, 0, "R3");
        run_cmd(2, 1, 0, "R4");  // detached target
        run_cmd(2, 3, 3, "R4");  // self join
        run_cmd(2, 3, 0, "R4");  // 0 blocks on 3
        run_cmd(2, 3, 1, "R4");  // second waiter refused
        run_cmd(2, 1, 0, "R4");  // blocked caller refused
        run_cmd(1, 0, 0, "R11"); // blocked thread not addable
        run_cmd(3, 0, 0, "R6");  // exit of blocked thread refused
        run_cmd(4, 3, 0, "R7");  // clear of live thread refused
        run_cmd(3, 3, 0, "R6");  // exit 3, wakes 0
        run_cmd(2, 3, 0, "R5");  // join on done target
        run_cmd(3, 3, 0, "R6");  // double exit refused
        run_cmd(4, 0, 0, "R7");  // clear of ready thread refused
        run_cmd(4, 3, 0, "R7");  // release 3
        run_cmd(4, 2, 0, "R8");  // idle thread cannot be released
        run_cmd(6, 4, 0, "R10");
        run_cmd(7, 0, 0, "R10");
        run_cmd(0, 0, 0, "R7");  // reuses 3
        quiet_cycle();
        for (int k = 0; k < 252; k++) run_cmd(0, 0, k % 2, "R2");
        run_cmd(0, 0, 0, "R2");  // full
        run_cmd(1, 100, 0, "R3");
        run_cmd(3, 100, 0, "R6");
        run_cmd(2, 100, 0, "R5");
        run_cmd(4, 100, 0, "R7");
        run_cmd(0, 0, 0, "R7");  // -> 100
        run_cmd(0, 0, 0, "R2");  // full again
        run_cmd(5, 7, 0, "R8");  // move idle to 7
        run_cmd(1, 2, 0, "R8");  // old idle now addable
        run_cmd(4, 7, 0, "R11"); // idle not done
        quiet_cycle();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule